// File: doc/BRIEF.md
# Interrupt Master Enable and Dispatch Unit

This unit sits next to the instruction sequencer of a small 8-bit processor. It owns the global interrupt enable, the per-source request latch and the per-source mask. It decides at instruction boundaries whether an interrupt is taken, and which one. The core signals enable, disable and return-from-interrupt instructions as single-cycle pulses, and marks every completed instruction with a retire strobe. In return the unit hands back a one-cycle acknowledge carrying the winning source number and its restart address.

The global enable has three states: off, on, and armed. An enable instruction only arms it, and the interrupt window opens once the instruction after it has completed. Disable and return-from-interrupt act on the next clock. When the core enters its low-power wait, the unit records a classification of the wake-up situation. Separately, it drives a wake line whenever an unmasked request is outstanding.

Top module: `intc_core`

## Requirements
- R1: After reset the global enable reads off (`imeState` = 0), the request latch reads 0xE0, the mask reads 0x00, `ackValid` is low, `wake` is low and `haltClass` is 0.
- R2: An `eiPulse` moves the global enable to armed (`imeState` = 2) with a count of zero. Each `retirePulse` seen while armed advances the count, and the retire that brings the count to 2 turns the enable on (`imeState` = 1) on the next clock. An `eiPulse` re-arms the enable even when it is already on.
- R3: A `diPulse` sets the global enable to off on the next clock from any state, and this cancels an armed enable.
- R4: A `retiPulse` sets the global enable to on at the next clock with no delay.
- R5: When several actions coincide in one cycle, the precedence is: dispatch or `diPulse` (off), then `retiPulse` (on), then `eiPulse` (armed), then `retirePulse` (count).
- R6: The request latch holds 5 bits. A read at address 0xFF0F returns them in bits 4..0, with bits 7..5 reading as 1. A bus write at 0xFF0F loads bits 4..0. A high bit of `srcSet` sets the matching bit, and this wins over a write or a dispatch clear in the same cycle.
- R7: The mask is a full 8-bit register, read and written at address 0xFFFF. A read of any other address returns 0x00.
- R8: A dispatch happens when `takeOk` is high, the enable is on and (request AND mask) over bits 4..0 is nonzero. The lowest-numbered such bit wins. On the next clock `ackValid` is high for exactly one cycle, `ackSrc` holds the bit index and `ackVector` holds 0x40 + 8 × index.
- R9: A dispatch clears the winning request bit and sets the global enable to off.
- R10: On `haltEnter` the unit registers `haltClass`: 2 if the enable is on, otherwise 1 if (request AND mask) is nonzero, otherwise 0. The value holds until the next `haltEnter`.
- R11: `wake` is high in the same cycle whenever (request AND mask) over bits 4..0 is nonzero, whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eiPulse | input | 1 | Enable-interrupts instruction executed |
| diPulse | input | 1 | Disable-interrupts instruction executed |
| retiPulse | input | 1 | Return-from-interrupt executed |
| retirePulse | input | 1 | An instruction has completed |
| haltEnter | input | 1 | Core enters low-power wait |
| takeOk | input | 1 | Core is at a boundary where a dispatch may occur |
| busAddr | input | 16 | Register access address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data (combinational) |
| srcSet | input | 5 | Per-source request set pulses |
| imeState | output | 2 | Global enable: 0 off, 1 on, 2 armed |
| ackValid | output | 1 | One-cycle dispatch acknowledge |
| ackSrc | output | 3 | Source index of the dispatch |
| ackVector | output | 8 | Restart address of the dispatch |
| haltClass | output | 2 | Wake-up class: 0 none pending, 1 some pending, 2 enable on |
| wake | output | 1 | Unmasked request outstanding |

## Verification
A wrong count in the armed state shows up at `imeState` one retire too early or too late. It also shows up as an acknowledge that arrives on the wrong clock once requests are waiting. A corrupted request or mask bit appears on the same cycle at `wake` and `busRdData`. A wrong priority or clear shows up as a wrong `ackSrc`/`ackVector` on the next dispatch. Because the reference model is compared on every clock, each such fault is reported within a cycle of the first port where it becomes visible.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    IME_OFF  = 2'd0,
    IME_ON   = 2'd1,
    IME_WAIT = 2'd2
  } imeState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       take;
    logic [2:0] idx;
  } dpStrobe_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 5,
  parameter logic [15:0] REQ_ADDR = 16'hFF0F,
  parameter logic [15:0] IE_ADDR  = 16'hFFFF,
  parameter int          VEC_BASE = 8'h40,
  parameter int          VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        busAddr,
  input  logic               busWrEn,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  input  logic [NUM_SRC-1:0] srcSet,
  input  dpStrobe_t          strobe,
  output logic               pendAny,
  output logic [2:0]         winIdx,
  output logic               ackValid,
  output logic [2:0]         ackSrc,
  output logic [7:0]         ackVector
);
  logic [NUM_SRC-1:0] reqQ, reqNext, pend, clrMask, reqBase;
  logic [7:0]         ieQ;
  logic               wrReq, wrIe;

  assign wrReq   = busWrEn && (busAddr == REQ_ADDR);
  assign wrIe    = busWrEn && (busAddr == IE_ADDR);
  assign pend    = reqQ & ieQ[NUM_SRC-1:0];
  assign pendAny = |pend;

  // lowest-numbered pending source wins
  always_comb begin
    winIdx = 3'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) winIdx = 3'(i);
    end
  end

  always_comb begin
    clrMask = '0;
    if (strobe.take) clrMask[strobe.idx] = 1'b1;
    reqBase = wrReq ? busWrData[NUM_SRC-1:0] : reqQ;
    reqNext = (reqBase & ~clrMask) | srcSet;
  end

  always_comb begin
    busRdData = 8'h00;
    if (busAddr == REQ_ADDR) begin
      busRdData = 8'hFF;
      busRdData[NUM_SRC-1:0] = reqQ;
    end else if (busAddr == IE_ADDR) begin
      busRdData = ieQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ      <= '0;
      ieQ       <= 8'h00;
      ackValid  <= 1'b0;
      ackSrc    <= 3'd0;
      ackVector <= 8'h00;
    end else begin
      reqQ     <= reqNext;
      if (wrIe) ieQ <= busWrData;
      ackValid <= strobe.take;
      if (strobe.take) begin
        ackSrc    <= strobe.idx;
        ackVector <= 8'(VEC_BASE + int'(strobe.idx) * VEC_STEP);
      end
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int PEND_RETIRES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      eiPulse,
  input  logic      diPulse,
  input  logic      retiPulse,
  input  logic      retirePulse,
  input  logic      haltEnter,
  input  logic      takeOk,
  input  logic      pendAny,
  input  logic [2:0] winIdx,
  output dpStrobe_t strobe,
  output imeState_t imeState,
  output logic [1:0] haltClass
);
  localparam int CW = $clog2(PEND_RETIRES + 1);

  imeState_t stQ, stNext;
  logic [CW-1:0] cntQ, cntNext;
  logic take;

  assign take       = takeOk && (stQ == IME_ON) && pendAny;
  assign strobe     = '{take: take, idx: winIdx};
  assign imeState   = stQ;

  always_comb begin
    stNext  = stQ;
    cntNext = cntQ;
    if (take || diPulse) begin
      stNext  = IME_OFF;
      cntNext = '0;
    end else if (retiPulse) begin
      stNext  = IME_ON;
      cntNext = '0;
    end else if (eiPulse) begin
      stNext  = IME_WAIT;
      cntNext = '0;
    end else if (retirePulse && stQ == IME_WAIT) begin
      if (cntQ == CW'(PEND_RETIRES - 1)) begin
        stNext  = IME_ON;
        cntNext = '0;
      end else begin
        cntNext = cntQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ       <= IME_OFF;
      cntQ      <= '0;
      haltClass <= 2'd0;
    end else begin
      stQ  <= stNext;
      cntQ <= cntNext;
      if (haltEnter) begin
        if (stQ == IME_ON)  haltClass <= 2'd2;
        else if (pendAny)   haltClass <= 2'd1;
        else                haltClass <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int          NUM_SRC      = 5,
  parameter int          PEND_RETIRES = 2,
  parameter logic [15:0] REQ_ADDR     = 16'hFF0F,
  parameter logic [15:0] IE_ADDR      = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               eiPulse,
  input  logic               diPulse,
  input  logic               retiPulse,
  input  logic               retirePulse,
  input  logic               haltEnter,
  input  logic               takeOk,
  input  logic [15:0]        busAddr,
  input  logic               busWrEn,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  input  logic [NUM_SRC-1:0] srcSet,
  output logic [1:0]         imeState,
  output logic               ackValid,
  output logic [2:0]         ackSrc,
  output logic [7:0]         ackVector,
  output logic [1:0]         haltClass,
  output logic               wake
);
  dpStrobe_t strobe;
  imeState_t stOut;
  logic      pendAny;
  logic [2:0] winIdx;

  intc_ctrl #(.PEND_RETIRES(PEND_RETIRES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .eiPulse(eiPulse), .diPulse(diPulse), .retiPulse(retiPulse),
    .retirePulse(retirePulse), .haltEnter(haltEnter), .takeOk(takeOk),
    .pendAny(pendAny), .winIdx(winIdx),
    .strobe(strobe), .imeState(stOut), .haltClass(haltClass)
  );

  intc_regs #(.NUM_SRC(NUM_SRC), .REQ_ADDR(REQ_ADDR), .IE_ADDR(IE_ADDR)) u_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .srcSet(srcSet), .strobe(strobe),
    .pendAny(pendAny), .winIdx(winIdx),
    .ackValid(ackValid), .ackSrc(ackSrc), .ackVector(ackVector)
  );

  assign imeState = stOut;
  assign wake     = pendAny;
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       eiPulse,
  input logic       diPulse,
  input logic       retiPulse,
  input logic       takeOk,
  input logic       haltEnter,
  input logic [1:0] imeState,
  input logic [1:0] haltClass,
  input logic       ackValid,
  input logic       wake
);
  p_state_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    imeState != 2'd3);

  p_ei_arms_r2: assert property (@(posedge clk) disable iff (!rstN)
    eiPulse && !diPulse && !retiPulse && !takeOk |=> imeState == 2'd2);

  p_di_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    diPulse |=> imeState == 2'd0);

  p_reti_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    retiPulse && !diPulse && !takeOk |=> imeState == 2'd1);

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  p_ack_after_wake_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackValid) |-> $past(wake) && $past(takeOk));

  p_take_disables_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> imeState == 2'd0);

  p_halt_on_r10: assert property (@(posedge clk) disable iff (!rstN)
    haltEnter && imeState == 2'd1 |=> haltClass == 2'd2);
endmodule

bind intc_core intc_core_chk u_chk (
  .clk(clk), .rstN(rstN), .eiPulse(eiPulse), .diPulse(diPulse),
  .retiPulse(retiPulse), .takeOk(takeOk), .haltEnter(haltEnter),
  .imeState(imeState), .haltClass(haltClass), .ackValid(ackValid),
  .wake(wake)
);

// File: tb/sim_intc_core.sv
`timescale 1ns/1ps
module sim_intc_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ei = 0, di = 0, reti = 0, ret = 0, halt = 0, tok = 0, wr = 0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdat = 8'h00;
  logic [4:0]  src = 5'h00;
  logic [7:0]  rdData;
  logic [1:0]  ime, hcls;
  logic        aV, wk;
  logic [2:0]  aS;
  logic [7:0]  aVec;

  int nChk = 0, nErr = 0;
  // reference state
  int mSt = 0, mCnt = 0, mReq = 0, mIe = 0, mHalt = 0, mAv = 0, mAs = 0, mAvec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_core u0 (
    .clk(clk), .rstN(rstN), .eiPulse(ei), .diPulse(di), .retiPulse(reti),
    .retirePulse(ret), .haltEnter(halt), .takeOk(tok), .busAddr(addr),
    .busWrEn(wr), .busWrData(wdat), .busRdData(rdData), .srcSet(src),
    .imeState(ime), .ackValid(aV), .ackSrc(aS), .ackVector(aVec),
    .haltClass(hcls), .wake(wk)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(int v);
    for (int i = 0; i < 5; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic clearIn();
    ei = 0; di = 0; reti = 0; ret = 0; halt = 0; wr = 0; src = 0;
  endtask

  // one clock with current inputs; model and DUT compared
  task automatic tick();
    int pend, take, idx, base, expRd;
    #1;
    pend = mReq & mIe & 'h1f;
    expRd = (addr == 16'hFF0F) ? ('hE0 | mReq) : (addr == 16'hFFFF) ? mIe : 0;
    chk("R6 R7 read data", rdData, expRd);
    chk("R11 wake", wk, (pend != 0) ? 1 : 0);
    take = (tok && mSt == 1 && pend != 0) ? 1 : 0;
    idx  = lowest(pend);
    if (halt) mHalt = (mSt == 1) ? 2 : (pend != 0) ? 1 : 0;
    if (take || di) begin mSt = 0; mCnt = 0; end
    else if (reti) begin mSt = 1; mCnt = 0; end
    else if (ei) begin mSt = 2; mCnt = 0; end
    else if (ret && mSt == 2) begin
      if (mCnt + 1 >= 2) begin mSt = 1; mCnt = 0; end
      else mCnt = mCnt + 1;
    end
    base = (wr && addr == 16'hFF0F) ? (wdat & 'h1f) : mReq;
    if (take) base = base & ~(1 << idx);
    mReq = (base | src) & 'h1f;
    if (wr && addr == 16'hFFFF) mIe = wdat;
    mAv = take;
    if (take) begin mAs = idx; mAvec = 'h40 + 8 * idx; end
    @(posedge clk);
    #1;
    chk("R2 R3 R4 R5 R9 ime state", ime, mSt);
    chk("R8 ack valid", aV, mAv);
    if (mAv) begin
      chk("R8 ack source", aS, mAs);
      chk("R8 ack vector", aVec, mAvec);
    end
    chk("R10 halt class", hcls, mHalt);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    clearIn(); addr = a; wdat = d; wr = 1; tick(); clearIn();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nChk++; nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    addr = 16'hFF0F; #1;
    chk("R1 req reset", rdData, 'hE0);
    chk("R1 ime reset", ime, 0);
    chk("R1 ack reset", aV, 0);
    chk("R1 halt reset", hcls, 0);
    chk("R1 wake reset", wk, 0);
    addr = 16'hFFFF; #1;
    chk("R1 ie reset", rdData, 0);

    // R7 mask write, other address reads 0
    busWrite(16'hFFFF, 8'hFF);
    addr = 16'h1234; tick();
    // R6 sources set bits 1 and 3
    tok = 1; src = 5'b01010; tick(); clearIn();
    // R10 halt while off with pending -> 1
    halt = 1; tick(); clearIn();
    // R2 EI then two retires before enable
    ei = 1; tick(); clearIn();
    ret = 1; tick(); clearIn();
    tick();
    ret = 1; tick(); clearIn();
    // R8 R9 dispatch of bit 1 now
    tick(); tick();
    // R4 reti gives immediate enable -> bit 3 dispatch
    reti = 1; tick(); clearIn();
    tick(); tick();
    // R10 halt while on, nothing pending -> 2
    reti = 1; tick(); clearIn();
    halt = 1; tick(); clearIn();
    // R3 DI cancels armed enable
    ei = 1; tick(); clearIn();
    ret = 1; tick(); clearIn();
    di = 1; tick(); clearIn();
    ret = 1; tick(); ret = 1; tick(); clearIn();
    // R10 none pending while off -> 0
    halt = 1; tick(); clearIn();
    // R6 source set wins over dispatch clear of the same bit
    src = 5'b00100; tick(); clearIn();
    reti = 1; tick(); clearIn();
    src = 5'b00100; tick(); clearIn();
    tick();
    // R5 coincident pulses
    ei = 1; reti = 1; tick(); clearIn();
    di = 1; reti = 1; ei = 1; tick(); clearIn();
    // R2 EI while already on re-arms
    reti = 1; tick(); clearIn();
    ei = 1; tick(); clearIn();
    // random traffic for every requirement
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      ei   = (r < 6);
      di   = ($urandom_range(0, 99) < 3);
      reti = ($urandom_range(0, 99) < 3);
      ret  = ($urandom_range(0, 99) < 40);
      halt = ($urandom_range(0, 99) < 5);
      tok  = ($urandom_range(0, 99) < 60);
      src  = ($urandom_range(0, 99) < 10) ? 5'($urandom_range(0, 31)) : 5'h00;
      wr   = ($urandom_range(0, 99) < 5);
      case ($urandom_range(0, 2))
        0: addr = 16'hFF0F;
        1: addr = 16'hFFFF;
        default: addr = 16'h00A0;
      endcase
      wdat = 8'($urandom_range(0, 255));
      tick();
    end
    clearIn();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule